// File: doc/BRIEF.md
# Delayed-Switch Memory Map Controller

This block sits beside a small processor and decides, for every memory cycle, whether the access goes to the board's own ROM, its scratch RAM, its timer window, or out to system memory. Two bits of a write-only I/O control register choose the map. One bit removes the ROM from the bottom of the address space. The other removes the upper ROM copy, the RAM and the timers together. An I/O read of a separate status port returns the map that is currently in force.

A write to the control register does not change the map at once. The new value is held as pending. It moves into the active map only after a fixed number of further CPU machine cycles have finished. A jump or call placed right after the write can therefore still fetch from the old map. Machine cycles that a DMA master owns do not advance the count. Every CPU machine cycle does, including interrupt-acknowledge cycles.

I/O port numbers are taken from the low address byte. A machine cycle is marked by a one-clock `cycleStart` pulse near its start.

Top module: `dmap_top`

## Requirements
- R1: After reset both map bits are 0. The ROM is selected at 0x0000–0x07FF and at 0xD800–0xDFFF, the RAM at 0xD000–0xD0FF, and the timers at 0xD100–0xD103.
- R2: Active map bit 6 (written from data bit 6), when 1, sends 0x0000–0x07FF to system memory instead of the ROM. When it is 0, the ROM is selected there.
- R3: Active map bit 7 (written from data bit 7), when 1, sends 0xD000–0xD0FF, 0xD100–0xD103 and 0xD800–0xDFFF to system memory. When it is 0, RAM, timers and ROM are selected there.
- R4: All four combinations of the two map bits are valid, so the ROM can appear in both ranges, in one of them, or in neither.
- R5: A control write is an ioWr with low address byte 0xF3 and dmaAck low. After such a write, the active map keeps its old value until the clock edge that samples the 4th counted cycleStart pulse after the write edge. That is, 3 machine cycles must finish after the write cycle. The new map is decoded from the following clock onward.
- R6: A cycleStart pulse that arrives while dmaAck is high is not counted. Every other cycleStart pulse is counted, whatever the cycle type, including cycles that carry no read or write strobe (interrupt acknowledge).
- R7: A control write while a change is pending replaces the pending value and restarts the count from zero.
- R8: While ioRd is high, dmaAck is low and the low address byte is 0x0F, statusOut is {active bit 7, active bit 6, 6'b0}. A pending value is never shown. At all other times statusOut is 0x00.
- R9: sysMemEn is 1 exactly when memRd or memWr is high and no onboard select (ROM, RAM, timer) is high.
- R10: Onboard selects are asserted only while memRd or memWr is high and dmaAck is low.
- R11: ioWr to any port other than 0xF3, and ioWr while dmaAck is high, leave the map untouched. Data bits 0–5 of a control write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| addr | input | 16 | CPU or DMA address; low byte is the I/O port |
| memRd | input | 1 | Memory read strobe |
| memWr | input | 1 | Memory write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioWr | input | 1 | I/O write strobe |
| cycleStart | input | 1 | One-clock pulse at the start of each machine cycle |
| dmaAck | input | 1 | High while a DMA master owns the bus |
| dataIn | input | 8 | Data bus toward the block |
| romSel | output | 1 | Onboard ROM select |
| ramSel | output | 1 | Onboard RAM select |
| timerSel | output | 1 | Onboard timer select |
| sysMemEn | output | 1 | Enables the system memory for this cycle |
| statusOut | output | 8 | Map status byte for a status-port read |

## Verification
The bench builds the block with its default parameters. These are a 3-cycle switch delay, control port 0xF3, status port 0x0F, and the windows above. The boundary addresses on both sides of every window can therefore be swept under each of the four map settings. The short delay also lets the bench exercise, in a handful of cycles, a switch that is still pending, one that is stretched by DMA-owned cycles, and one that a second write restarts.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

  // Strobes from the control FSM to the map datapath
  typedef struct packed {
    logic loadPending;  // capture a new map value into the pending register
    logic commit;       // move the pending value into the active map
  } mapStrobes_t;

endpackage

// File: rtl/dmap_ctrl.sv
module dmap_ctrl
  import dmap_pkg::*;
#(
  parameter int          DELAY_CYCLES = 3,
  parameter logic [7:0]  CTRL_PORT    = 8'hF3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  ioPort,
  input  logic        ioWr,
  input  logic        cycleStart,
  input  logic        dmaAck,
  output mapStrobes_t strobes
);

  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DELAY_CYCLES);

  logic             pendingValid;
  logic [CNT_W-1:0] tickCnt;
  logic             ctrlWrite;
  logic             tick;

  assign ctrlWrite = ioWr && !dmaAck && (ioPort == CTRL_PORT);
  // a CPU-owned cycle boundary while a change waits
  assign tick      = cycleStart && !dmaAck && pendingValid && !ctrlWrite;

  assign strobes.loadPending = ctrlWrite;
  assign strobes.commit      = tick && (tickCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingValid <= 1'b0;
      tickCnt      <= '0;
    end else if (ctrlWrite) begin
      pendingValid <= 1'b1;
      tickCnt      <= '0;
    end else if (strobes.commit) begin
      pendingValid <= 1'b0;
      tickCnt      <= '0;
    end else if (tick) begin
      tickCnt      <= tickCnt + 1'b1;
    end
  end

  // R6: a DMA-owned cycle boundary leaves the count and the pending flag alone
  p_dma_no_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && pendingValid) |=> (pendingValid && tickCnt == $past(tickCnt)));

  // R7: a control write always restarts the count
  p_write_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (pendingValid && tickCnt == '0));

endmodule

// File: rtl/dmap_path.sv
module dmap_path
  import dmap_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [7:0]  STAT_PORT   = 8'h0F,
  parameter logic [15:0] ROM_LO_BASE = 16'h0000,
  parameter logic [15:0] ROM_HI_BASE = 16'hD800,
  parameter int          ROM_BYTES   = 2048,
  parameter logic [15:0] RAM_BASE    = 16'hD000,
  parameter int          RAM_BYTES   = 256,
  parameter logic [15:0] TMR_BASE    = 16'hD100,
  parameter int          TMR_BYTES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memRd,
  input  logic              memWr,
  input  logic              ioRd,
  input  logic              dmaAck,
  input  logic [1:0]        mapBitsIn,   // data bits 7:6
  input  mapStrobes_t       strobes,
  output logic              romSel,
  output logic              ramSel,
  output logic              timerSel,
  output logic              sysMemEn,
  output logic [7:0]        statusOut
);

  localparam int AW1 = ADDR_W + 1;

  function automatic logic inWin(input logic [ADDR_W-1:0] a,
                                 input logic [15:0] base,
                                 input int unsigned bytes);
    logic [AW1-1:0] lo;
    logic [AW1-1:0] hi;
    logic [AW1-1:0] av;
    lo = AW1'(base);
    hi = lo + AW1'(bytes);
    av = {1'b0, a};
    return (av >= lo) && (av < hi);
  endfunction

  // bit 1 = map bit 7 (upper window off), bit 0 = map bit 6 (low ROM off)
  logic [1:0] pendingMap;
  logic [1:0] activeMap;
  logic       memAny;
  logic       cpuMem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingMap <= 2'b00;
      activeMap  <= 2'b00;
    end else begin
      if (strobes.loadPending) pendingMap <= mapBitsIn;
      if (strobes.commit)      activeMap  <= pendingMap;
    end
  end

  assign memAny = memRd || memWr;
  assign cpuMem = memAny && !dmaAck;

  always_comb begin
    romSel   = cpuMem && ((!activeMap[0] && inWin(addr, ROM_LO_BASE, ROM_BYTES)) ||
                          (!activeMap[1] && inWin(addr, ROM_HI_BASE, ROM_BYTES)));
    ramSel   = cpuMem && !activeMap[1] && inWin(addr, RAM_BASE, RAM_BYTES);
    timerSel = cpuMem && !activeMap[1] && inWin(addr, TMR_BASE, TMR_BYTES);
    sysMemEn = memAny && !(romSel || ramSel || timerSel);
    statusOut = 8'h00;
    if (ioRd && !dmaAck && addr[7:0] == STAT_PORT)
      statusOut = {activeMap[1], activeMap[0], 6'b0};
  end

  // R5: the active map moves only on a commit strobe from the control side
  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(activeMap));

  // R9: onboard select and system memory never enabled together
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rstN)
    (romSel || ramSel || timerSel) |-> !sysMemEn);

  // R10: no onboard select during DMA ownership
  p_dma_suppress_r10: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |-> !(romSel || ramSel || timerSel));

  // R10: at most one onboard device selected
  p_one_select_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romSel, ramSel, timerSel}));

  // R8: unused status bits read as zero
  p_status_low_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[5:0] == 6'b0);

endmodule

// File: rtl/dmap_top.sv
module dmap_top
  import dmap_pkg::*;
#(
  parameter int          DELAY_CYCLES = 3,
  parameter logic [7:0]  CTRL_PORT    = 8'hF3,
  parameter logic [7:0]  STAT_PORT    = 8'h0F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] addr,
  input  logic        memRd,
  input  logic        memWr,
  input  logic        ioRd,
  input  logic        ioWr,
  input  logic        cycleStart,
  input  logic        dmaAck,
  input  logic [7:0]  dataIn,
  output logic        romSel,
  output logic        ramSel,
  output logic        timerSel,
  output logic        sysMemEn,
  output logic [7:0]  statusOut
);

  mapStrobes_t strobes;
  logic        unusedData;

  assign unusedData = ^dataIn[5:0];

  dmap_ctrl #(
    .DELAY_CYCLES(DELAY_CYCLES),
    .CTRL_PORT   (CTRL_PORT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ioPort    (addr[7:0]),
    .ioWr      (ioWr),
    .cycleStart(cycleStart),
    .dmaAck    (dmaAck),
    .strobes   (strobes)
  );

  dmap_path #(
    .ADDR_W   (16),
    .STAT_PORT(STAT_PORT)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .memRd    (memRd),
    .memWr    (memWr),
    .ioRd     (ioRd),
    .dmaAck   (dmaAck),
    .mapBitsIn(dataIn[7:6]),
    .strobes  (strobes),
    .romSel   (romSel),
    .ramSel   (ramSel),
    .timerSel (timerSel),
    .sysMemEn (sysMemEn),
    .statusOut(statusOut)
  );

endmodule

// File: tb/tb_dmap_top.sv
`timescale 1ns/1ps
module tb_dmap_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        memRd = 0, memWr = 0, ioRd = 0, ioWr = 0;
  logic        cycleStart = 0, dmaAck = 0;
  logic [7:0]  dataIn = '0;
  logic        romSel, ramSel, timerSel, sysMemEn;
  logic [7:0]  statusOut;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    done = 0;

  // behavioural reference state
  int mBit6 = 0, mBit7 = 0;
  int pBit6 = 0, pBit7 = 0;
  int pendFlag = 0, pendCount = 0;

  always #10 clk = ~clk;

  dmap_top dut (
    .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr),
    .ioRd(ioRd), .ioWr(ioWr), .cycleStart(cycleStart), .dmaAck(dmaAck),
    .dataIn(dataIn), .romSel(romSel), .ramSel(ramSel), .timerSel(timerSel),
    .sysMemEn(sysMemEn), .statusOut(statusOut)
  );

  // compare every clock, then advance the model as the coming edge will
  always @(negedge clk) begin
    int a;
    bit memAct, eRom, eRam, eTmr, eSys;
    logic [7:0] eStat;
    a      = addr;
    memAct = (memRd || memWr) && !dmaAck;
    eRom   = memAct && ((mBit6 == 0 && a < 'h800) ||
                        (mBit7 == 0 && a >= 'hD800 && a <= 'hDFFF));
    eRam   = memAct && mBit7 == 0 && a >= 'hD000 && a <= 'hD0FF;
    eTmr   = memAct && mBit7 == 0 && a >= 'hD100 && a <= 'hD103;
    eSys   = (memRd || memWr) && !(eRom || eRam || eTmr);
    eStat  = (ioRd && !dmaAck && addr[7:0] == 8'h0F) ?
             {mBit7[0], mBit6[0], 6'b0} : 8'h00;
    checks++;
    if ({romSel, ramSel, timerSel, sysMemEn, statusOut} !=
        {eRom, eRam, eTmr, eSys, eStat}) begin
      errors++;
      $display("FAIL %s addr=%h rom/ram/tmr/sys/stat act=%b%b%b%b/%h exp=%b%b%b%b/%h",
               curReq, addr, romSel, ramSel, timerSel, sysMemEn, statusOut,
               eRom, eRam, eTmr, eSys, eStat);
    end
    if (!rstN) begin
      mBit6 = 0; mBit7 = 0; pBit6 = 0; pBit7 = 0; pendFlag = 0; pendCount = 0;
    end else if (ioWr && !dmaAck && addr[7:0] == 8'hF3) begin
      pBit6 = dataIn[6]; pBit7 = dataIn[7]; pendFlag = 1; pendCount = 0;
    end else if (cycleStart && !dmaAck && pendFlag != 0) begin
      pendCount++;
      if (pendCount == 4) begin
        mBit6 = pBit6; mBit7 = pBit7; pendFlag = 0; pendCount = 0;
      end
    end
  end

  task automatic busCyc(input logic [15:0] a, input logic mr, input logic mw,
                        input logic ir, input logic iw, input logic dma,
                        input logic [7:0] d);
    @(posedge clk); #2;
    addr = a; memRd = mr; memWr = mw; ioRd = ir; ioWr = iw;
    dmaAck = dma; dataIn = d; cycleStart = 1'b1;
    @(posedge clk); #2;
    cycleStart = 1'b0;
  endtask

  task automatic idleCyc();   // interrupt-acknowledge-like cycle, no strobes
    busCyc(16'h0000, 0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic sweep(input logic mr, input logic mw, input logic dma);
    logic [15:0] pts [14] = '{16'h0000, 16'h07FF, 16'h0800, 16'hCFFF,
                              16'hD000, 16'hD0FF, 16'hD100, 16'hD103,
                              16'hD104, 16'hD7FF, 16'hD800, 16'hDFFF,
                              16'hE000, 16'hFFFF};
    for (int i = 0; i < 14; i++) busCyc(pts[i], mr, mw, 0, 0, dma, 8'h00);
  endtask

  task automatic statRead();
    busCyc(16'h000F, 0, 0, 1, 0, 0, 8'h00);
  endtask

  task automatic ctrlWrite(input logic [7:0] d);
    busCyc(16'h00F3, 0, 0, 0, 1, 0, d);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    curReq = "R1";
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    sweep(1, 0, 0);
    statRead();
    curReq = "R10";
    sweep(0, 0, 0);
    sweep(0, 1, 0);
    sweep(1, 0, 1);
    curReq = "R2";
    ctrlWrite(8'h40);
    curReq = "R5";
    statRead(); sweep(1, 0, 0);
    curReq = "R2";
    sweep(1, 0, 0); statRead();
    curReq = "R3";
    ctrlWrite(8'h80);
    repeat (4) idleCyc();
    sweep(1, 0, 0); statRead();
    curReq = "R4";
    ctrlWrite(8'hC0);
    repeat (4) idleCyc();
    sweep(0, 1, 0); statRead();
    ctrlWrite(8'h00);
    repeat (4) idleCyc();
    sweep(1, 0, 0);
    curReq = "R6";
    ctrlWrite(8'hC0);
    idleCyc();
    repeat (3) busCyc(16'hD000, 1, 0, 0, 0, 1, 8'h00);
    busCyc(16'h0000, 1, 0, 0, 0, 0, 8'h00);
    busCyc(16'hD800, 1, 0, 0, 0, 1, 8'h00);
    busCyc(16'hD800, 1, 0, 0, 0, 0, 8'h00);
    busCyc(16'h0100, 1, 0, 0, 0, 0, 8'h00);
    statRead(); statRead();
    curReq = "R7";
    ctrlWrite(8'h40);
    busCyc(16'h0010, 1, 0, 0, 0, 0, 8'h00);
    busCyc(16'h0010, 1, 0, 0, 0, 0, 8'h00);
    ctrlWrite(8'h80);
    busCyc(16'h0010, 1, 0, 0, 0, 0, 8'h00);
    busCyc(16'hD010, 1, 0, 0, 0, 0, 8'h00);
    statRead();
    busCyc(16'h0010, 1, 0, 0, 0, 0, 8'h00);
    busCyc(16'hD010, 1, 0, 0, 0, 0, 8'h00);
    statRead();
    curReq = "R11";
    busCyc(16'h00F4, 0, 0, 0, 1, 0, 8'hFF);
    busCyc(16'h01F2, 0, 0, 0, 1, 0, 8'hFF);
    busCyc(16'h00F3, 0, 0, 0, 1, 1, 8'hFF);
    repeat (5) idleCyc();
    sweep(1, 0, 0); statRead();
    ctrlWrite(8'h3F);
    repeat (5) idleCyc();
    sweep(1, 0, 0); statRead();
    curReq = "R8";
    busCyc(16'h000F, 0, 0, 1, 0, 1, 8'h00);
    busCyc(16'h000E, 0, 0, 1, 0, 0, 8'h00);
    ctrlWrite(8'hC0);
    statRead(); statRead();
    curReq = "R9";
    repeat (3) idleCyc();
    sweep(1, 0, 0);
    busCyc(16'hD000, 1, 0, 1, 0, 0, 8'h00);
    @(posedge clk); #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule